// File: doc/BRIEF.md
# Infrared Receive-Bandwidth Programming Sequencer

This block sits between a serial data path and the two control pins of an infrared transceiver: the shutdown/mode line and the transmit-data line. The transceiver picks its receive bandwidth on each falling edge of the shutdown line. It reads the transmit-data line at that moment: low selects the slow band (SIR/MIR) and high selects the fast band (FIR). The sequencer makes that handshake. It holds the shutdown line high for a lead interval and then for a set-up interval, with the mode bit placed on the transmit-data line. It then drops the shutdown line and keeps the mode bit steady through a hold interval. After that it hands the transmit-data line back to the data path.

A one-cycle `req` pulse starts a sequence, and `req_fir` gives the mode. While a sequence runs, `busy` is high and the data path cannot reach the transmit-data line. `done` pulses for one cycle when the sequence ends. A separate level input, `sdn_req`, keeps the transceiver in shutdown for as long as it is held. The transceiver wakes in the slow band, so releasing `sdn_req` starts an automatic reprogram of the last mode that was accepted. Every interval is a cycle count, rounded up at elaboration from a nanosecond minimum and the clock period. All control pins are plain levels, because no data stream passes through the block.

Top module: `irbw_seq`

## Requirements
- R1: After reset, and whenever no sequence or shutdown is active, `sd_out`, `busy` and `done` are low and `txd_out` equals `tx_data_in`.
- R2: `req_fir`=0 (slow band) is accepted with `req`. From the next cycle, `sd_out` is high for 4 cycles (2 lead + 2 set-up at the default 20 ns clock) with `txd_out` low. Then `sd_out` is low for 5 hold cycles with `txd_out` low.
- R3: `txd_out` does not change in the cycle in which `sd_out` falls, nor in the following hold cycles, whose count is rounded up from 100 ns.
- R4: `req_fir`=1 (fast band) is accepted with `req`. `sd_out` is high for 2 lead cycles with `txd_out` low, then for 2 set-up cycles with `txd_out` high. Then `sd_out` is low for 5 hold cycles with `txd_out` still high, after which `txd_out` follows `tx_data_in` again.
- R5: While `busy` is high, `tx_data_in` has no effect on `txd_out`. `busy` is high whenever `sd_out` is high.
- R6: `done` is high for exactly one cycle, the cycle after the last hold cycle. `busy` is low in that cycle.
- R7: A `req` that arrives while `busy` is high is ignored. The running sequence keeps its mode, and no second sequence follows.
- R8: When `sdn_req` is high while the block is idle, then from the next cycle until release `sd_out` is high, `txd_out` is low and `busy` is high. `req` is ignored during that time.
- R9: On release of `sdn_req`, the block drives 2 set-up cycles (`sd_out` high, `txd_out` = last accepted mode) and then 5 hold cycles, and `done` pulses.
- R10: `sdn_req` raised during a programming sequence has no effect until that sequence completes. Shutdown starts in the cycle after `done`.
- R11: After reset the last accepted mode is the slow band. In an idle cycle, `sdn_req` takes priority over a simultaneous `req`, and that `req` is dropped.
- R12: Every high pulse on `sd_out` lasts at least the mode-select minimum, which is strictly more than 50 ns (3 cycles at default).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | 1 | One-cycle programming request |
| req_fir | input | 1 | Mode bit with `req`: 1 fast band, 0 slow band |
| sdn_req | input | 1 | Level: hold transceiver in shutdown while high |
| tx_data_in | input | 1 | Serial transmit data from the data path |
| sd_out | output | 1 | Shutdown/mode pin drive |
| txd_out | output | 1 | Transmit-data pin drive |
| busy | output | 1 | Sequence or shutdown in progress |
| done | output | 1 | One-cycle pulse at end of a sequence |

## Verification
The assertions rely on two things about the inputs. `tx_data_in` is the only input that reaches `txd_out` outside a sequence, and no input changes within a clock edge. Under those conditions, every falling edge of `sd_out` is a programming edge whose pulse width and hold window can be measured in cycles. The stimulus changes every input half a cycle away from the sampling edge. It pulses `req` for a single cycle and treats `sdn_req` as a slow level. It pokes requests and shutdown into chosen phase cycles, so that the ignore and defer rules are exercised at known points.

// File: rtl/irbw_pkg.sv
package irbw_pkg;

  typedef enum logic [2:0] {
    PH_IDLE  = 3'd0,
    PH_LEAD  = 3'd1,
    PH_SETUP = 3'd2,
    PH_HOLD  = 3'd3,
    PH_SHDN  = 3'd4
  } phase_e;

  // at-least rounding: ceil(a/b)
  function automatic int cyc_atleast(input int a, input int b);
    return (a + b - 1) / b;
  endfunction

  // strictly-more-than rounding
  function automatic int cyc_above(input int a, input int b);
    return a / b + 1;
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/irbw_timer.sv
module irbw_timer #(
  parameter int CW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic          expired
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt_q <= '0;
    else if (load)         cnt_q <= load_val;
    else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
  end

  assign expired = (cnt_q == '0);
endmodule

// File: rtl/irbw_fsm.sv
module irbw_fsm
  import irbw_pkg::*;
#(
  parameter int CW       = 3,
  parameter int LEAD_CYC = 2,
  parameter int SET_CYC  = 2,
  parameter int HOLD_CYC = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req,
  input  logic          req_fir,
  input  logic          sdn_req,
  input  logic          expired,
  output phase_e        phase,
  output logic          mode_fir,
  output logic          load,
  output logic [CW-1:0] load_val,
  output logic          done
);
  phase_e ph_q, ph_d;
  logic   accept;

  assign accept = (ph_q == PH_IDLE) && !sdn_req && req;

  always_comb begin
    ph_d     = ph_q;
    load     = 1'b0;
    load_val = '0;
    case (ph_q)
      PH_IDLE: begin
        if (sdn_req) ph_d = PH_SHDN;
        else if (req) begin
          ph_d = PH_LEAD; load = 1'b1; load_val = CW'(LEAD_CYC - 1);
        end
      end
      PH_LEAD: if (expired) begin
        ph_d = PH_SETUP; load = 1'b1; load_val = CW'(SET_CYC - 1);
      end
      PH_SETUP: if (expired) begin
        ph_d = PH_HOLD; load = 1'b1; load_val = CW'(HOLD_CYC - 1);
      end
      PH_HOLD: if (expired) ph_d = PH_IDLE;
      PH_SHDN: if (!sdn_req) begin
        ph_d = PH_SETUP; load = 1'b1; load_val = CW'(SET_CYC - 1);
      end
      default: ph_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q     <= PH_IDLE;
      mode_fir <= 1'b0;
      done     <= 1'b0;
    end else begin
      ph_q <= ph_d;
      if (accept) mode_fir <= req_fir;
      done <= (ph_q == PH_HOLD) && expired;
    end
  end

  assign phase = ph_q;
endmodule

// File: rtl/irbw_pinmux.sv
module irbw_pinmux
  import irbw_pkg::*;
(
  input  phase_e phase,
  input  logic   mode_fir,
  input  logic   tx_data_in,
  output logic   sd_out,
  output logic   txd_out,
  output logic   busy
);
  always_comb begin
    sd_out  = 1'b0;
    txd_out = 1'b0;
    case (phase)
      PH_IDLE:  txd_out = tx_data_in;
      PH_LEAD:  sd_out  = 1'b1;
      PH_SETUP: begin sd_out = 1'b1; txd_out = mode_fir; end
      PH_HOLD:  txd_out = mode_fir;
      PH_SHDN:  sd_out  = 1'b1;
      default:  ;
    endcase
  end

  assign busy = (phase != PH_IDLE);
endmodule

// File: rtl/irbw_seq.sv
module irbw_seq
  import irbw_pkg::*;
#(
  parameter int CLK_NS   = 20,
  parameter int LEAD_NS  = 25,
  parameter int SETUP_NS = 25,
  parameter int HOLD_NS  = 100,
  parameter int PULSE_NS = 50
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req,
  input  logic req_fir,
  input  logic sdn_req,
  input  logic tx_data_in,
  output logic sd_out,
  output logic txd_out,
  output logic busy,
  output logic done
);
  localparam int LEAD_CYC = cyc_above(LEAD_NS, CLK_NS);
  localparam int PW_CYC   = cyc_above(PULSE_NS, CLK_NS);
  localparam int SET_CYC  = imax(imax(cyc_atleast(SETUP_NS, CLK_NS), PW_CYC - LEAD_CYC), 1);
  localparam int HOLD_CYC = imax(cyc_atleast(HOLD_NS, CLK_NS), 1);
  localparam int MAX_CYC  = imax(imax(LEAD_CYC, SET_CYC), HOLD_CYC);
  localparam int CW       = imax($clog2(MAX_CYC + 1), 1);

  phase_e        phase;
  logic          mode_fir, load, expired;
  logic [CW-1:0] load_val;

  irbw_timer #(.CW(CW)) u_timer (
    .clk(clk), .rst_n(rst_n), .load(load), .load_val(load_val), .expired(expired)
  );

  irbw_fsm #(
    .CW(CW), .LEAD_CYC(LEAD_CYC), .SET_CYC(SET_CYC), .HOLD_CYC(HOLD_CYC)
  ) u_fsm (
    .clk(clk), .rst_n(rst_n), .req(req), .req_fir(req_fir), .sdn_req(sdn_req),
    .expired(expired), .phase(phase), .mode_fir(mode_fir), .load(load),
    .load_val(load_val), .done(done)
  );

  irbw_pinmux u_pins (
    .phase(phase), .mode_fir(mode_fir), .tx_data_in(tx_data_in),
    .sd_out(sd_out), .txd_out(txd_out), .busy(busy)
  );
endmodule

// File: rtl/irbw_seq_chk.sv
module irbw_seq_chk #(
  parameter int PW_MIN   = 3,
  parameter int HOLD_MIN = 5
) (
  input logic clk,
  input logic rst_n,
  input logic sdn_req,
  input logic sd_out,
  input logic txd_out,
  input logic busy,
  input logic done
);
  logic sd_q, txd_q;
  int   hi_cnt, lo_cnt;
  logic sd_fall;

  assign sd_fall = sd_q && !sd_out;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sd_q <= 1'b0; txd_q <= 1'b0; hi_cnt <= 0; lo_cnt <= 0;
    end else begin
      sd_q  <= sd_out;
      txd_q <= txd_out;
      if (sd_out) hi_cnt <= (hi_cnt < PW_MIN) ? hi_cnt + 1 : hi_cnt;
      else        hi_cnt <= 0;
      if (sd_fall)                              lo_cnt <= 1;
      else if (lo_cnt != 0 && lo_cnt < HOLD_MIN - 1) lo_cnt <= lo_cnt + 1;
      else                                      lo_cnt <= 0;
    end
  end

  assert_pulse_width_R12: assert property (@(posedge clk) disable iff (!rst_n)
    sd_fall |-> hi_cnt >= PW_MIN);

  assert_txd_at_edge_R3: assert property (@(posedge clk) disable iff (!rst_n)
    sd_fall |-> txd_out == txd_q);

  assert_txd_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (lo_cnt != 0) |-> txd_out == txd_q);

  assert_done_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_done_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  assert_sd_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
    sd_out |-> busy);

  assert_shdn_entry_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (sdn_req && !busy) |=> sd_out);
endmodule

bind irbw_seq irbw_seq_chk #(.PW_MIN(PW_CYC), .HOLD_MIN(HOLD_CYC)) u_chk (
  .clk(clk), .rst_n(rst_n), .sdn_req(sdn_req), .sd_out(sd_out),
  .txd_out(txd_out), .busy(busy), .done(done)
);

// File: tb/sim_irbw_seq.sv
module sim_irbw_seq;
  localparam int LEAD = 2, SETC = 2, HOLD = 5;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n, req, req_fir, sdn_req, tx_data_in;
  logic sd_out, txd_out, busy, done;
  int   n_run = 0, n_fail = 0;

  irbw_seq u0 (
    .clk(clk), .rst_n(rst_n), .req(req), .req_fir(req_fir), .sdn_req(sdn_req),
    .tx_data_in(tx_data_in), .sd_out(sd_out), .txd_out(txd_out),
    .busy(busy), .done(done)
  );

  // compare {sd_out, txd_out, busy, done}
  task automatic chk(input string tag, input logic [3:0] exp);
    logic [3:0] act;
    act = {sd_out, txd_out, busy, done};
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual={sd,txd,busy,done}=%b expected=%b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; req = 1'b0; req_fir = 1'b0; sdn_req = 1'b0; tx_data_in = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic start_req(input logic fir);
    req = 1'b1; req_fir = fir;
    @(negedge clk);
    req = 1'b0;
  endtask

  // walk one programming sequence; poke_kind 1 = req with opposite mode, 2 = raise sdn_req
  task automatic expect_seq(input logic fir, input int lead, input string tag,
                            input int poke_at, input int poke_kind);
    int total;
    total = lead + SETC + HOLD;
    for (int i = 0; i < total; i++) begin
      if (i < lead)              chk(tag, {1'b1, 1'b0, 1'b1, 1'b0});
      else if (i < lead + SETC)  chk(tag, {1'b1, fir,  1'b1, 1'b0});
      else                       chk(tag, {1'b0, fir,  1'b1, 1'b0});
      if (i == poke_at && poke_kind == 1) begin req = 1'b1; req_fir = ~fir; end
      else req = 1'b0;
      if (i == poke_at && poke_kind == 2) sdn_req = 1'b1;
      @(negedge clk);
    end
    req = 1'b0;
    chk({tag, " done R6"}, {1'b0, tx_data_in, 1'b0, 1'b1});
  endtask

  task automatic t_reset();
    do_reset();
    tx_data_in = 1'b1; #1;
    chk("R1 reset pass high", 4'b0100);
    tx_data_in = 1'b0; #1;
    chk("R1 reset pass low", 4'b0000);
  endtask

  task automatic t_sir();
    tx_data_in = 1'b1;           // R5: must not reach the pin while busy
    start_req(1'b0);
    expect_seq(1'b0, LEAD, "R2 R5 slow band", -1, 0);
    @(negedge clk);
    chk("R1 idle after slow", 4'b0100);
  endtask

  task automatic t_fir();
    tx_data_in = 1'b0;
    start_req(1'b1);
    expect_seq(1'b1, LEAD, "R4 R3 fast band", -1, 0);
    @(negedge clk);
    chk("R4 data path back", 4'b0000);
  endtask

  task automatic t_busy_ignore();
    tx_data_in = 1'b0;
    start_req(1'b1);
    expect_seq(1'b1, LEAD, "R7 mode kept", 3, 1);
    repeat (3) begin
      @(negedge clk);
      chk("R7 no second sequence", 4'b0000);
    end
  endtask

  task automatic t_shutdown(input logic last_fir, input string tag);
    sdn_req = 1'b1;
    @(negedge clk);
    chk({tag, " R8 enter"}, 4'b1010);
    for (int k = 0; k < 20; k++) begin
      req = (k == 5); req_fir = ~last_fir;
      @(negedge clk);
    end
    chk({tag, " R8 held, req ignored"}, 4'b1010);
    sdn_req = 1'b0;
    @(negedge clk);
    expect_seq(last_fir, 0, {tag, " R9 reprogram"}, -1, 0);
  endtask

  task automatic t_defer();
    tx_data_in = 1'b0;
    start_req(1'b0);
    expect_seq(1'b0, LEAD, "R10 seq unaffected", 2, 2);
    @(negedge clk);
    chk("R10 shutdown after done", 4'b1010);
    sdn_req = 1'b0;
    @(negedge clk);
    expect_seq(1'b0, 0, "R10 R9 reprogram slow", -1, 0);
  endtask

  task automatic t_default_mode();
    do_reset();
    t_shutdown(1'b0, "R11 default slow");
    // simultaneous sdn_req and req in idle: shutdown wins, req dropped
    @(negedge clk);
    sdn_req = 1'b1; req = 1'b1; req_fir = 1'b1;
    @(negedge clk);
    req = 1'b0;
    chk("R11 priority shutdown", 4'b1010);
    sdn_req = 1'b0;
    @(negedge clk);
    expect_seq(1'b0, 0, "R11 dropped req mode", -1, 0);
  endtask

  initial begin
    t_reset();
    t_sir();
    t_fir();
    t_busy_ignore();
    t_shutdown(1'b1, "fast last");
    t_defer();
    t_default_mode();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog all requirements actual=timeout expected=finished");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule